// File: doc/BRIEF.md
# Serial Port Character FIFO and Interrupt Controller

This block sits between the host bus and the serial shift registers of an asynchronous serial port. It holds a receive queue and a transmit queue of byte-wide characters, 16 entries each by default, and turns their fill levels and receiver error events into interrupt requests. The host pushes transmit characters and pops received characters through byte-wide ports. The serial shifters push received characters and pop characters to send through a second pair of byte-wide ports.

Software sets the block up through a small word-wide register set. Each queue has a control word with an enable, a one-shot flush and an interrupt trigger level. A single status word reports the receive fill, the transmit fill and the transmit free-slot count. An enable word gates four interrupt outputs. A capture word holds the pending transmit, receive and error requests, and writing a one to a bit of it clears that request.

Register indices on `reg_addr` are: 0 receive control, 1 transmit control, 2 status (read only), 3 interrupt enable, 4 interrupt capture. Reads are combinational from `reg_addr`.

Top module: `uart_fifo_irq`

## Requirements
- R1: After reset both queues are empty and disabled, both control words and the enable and capture words read 0, the status word reads 0x10000000 (16 free transmit slots), and all four interrupt outputs are low.
- R2: Each queue holds up to 16 characters and delivers them in the order they were pushed; the head character is shown on the pop data port while the queue is not empty, and `shf_tx_valid` is high exactly while the transmit queue holds a character.
- R3: The status word carries the receive fill count in bits 5:0, the transmit fill count in bits 13:8 and the transmit free-slot count (16 minus the fill) in bits 29:24, all other bits 0.
- R4: A control word keeps its enable in bit 0 and a 6-bit trigger level in bits 13:8, both read back as written; while a queue's enable is 0, pushes into it are dropped.
- R5: Writing a control word with bit 1 set empties that queue at the same clock edge; bit 1 always reads back as 0.
- R6: A push into a full queue is dropped and leaves its contents unchanged; a pop from an empty receive queue returns 0 and leaves the count at 0.
- R7: The receive request (capture bit 1) becomes pending while the receive queue is enabled and its fill count is at or above the receive trigger level.
- R8: The transmit request (capture bit 0) becomes pending while the transmit queue is enabled and its fill count is at or below the transmit trigger level.
- R9: A one-cycle pulse on `shf_rx_err` makes the error request (capture bit 2) pending.
- R10: Enable-word bit 0 gates `irq_tx`, bit 1 gates `irq_rx`, bit 2 gates `irq_err`; a request becomes pending in the capture word whatever its enable bit.
- R11: Writing a 1 to a capture bit clears that request unless its condition still holds at that edge, in which case it stays pending; writing 0 to a capture bit has no effect.
- R12: `irq_txbuf` is high while enable-word bit 3 is set and the transmit fill count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| host_tx_push | input | 1 | Host pushes a transmit character |
| host_tx_data | input | 8 | Character pushed by the host |
| host_rx_pop | input | 1 | Host pops a received character |
| host_rx_data | output | 8 | Head of the receive queue, 0 when empty |
| shf_rx_push | input | 1 | Receive shifter pushes a character |
| shf_rx_data | input | 8 | Character from the receive shifter |
| shf_rx_err | input | 1 | Receive error event pulse |
| shf_tx_pop | input | 1 | Transmit shifter takes a character |
| shf_tx_data | output | 8 | Head of the transmit queue, 0 when empty |
| shf_tx_valid | output | 1 | Transmit queue not empty |
| irq_tx | output | 1 | Transmit interrupt request |
| irq_rx | output | 1 | Receive interrupt request |
| irq_err | output | 1 | Error interrupt request |
| irq_txbuf | output | 1 | Transmit queue fully empty request |

## Verification
Pushes, pops and flushes take effect at the clock edge that samples them, so fill counts, status and head data are due right after that edge; capture bits follow the fill counts one edge later, and the error bit follows its pulse at the sampling edge. Enable-word changes and `irq_txbuf` act on the outputs at once from registered state. The bench drives every input on a falling edge and samples on the next falling edge, adding one idle cycle before each check of a fill-driven capture bit, so every sample lands after the edge that produces it.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    // register indices
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_RXCTL = 3'd0;
    localparam logic [ADDR_W-1:0] A_TXCTL = 3'd1;
    localparam logic [ADDR_W-1:0] A_STAT  = 3'd2;
    localparam logic [ADDR_W-1:0] A_IEN   = 3'd3;
    localparam logic [ADDR_W-1:0] A_ICAP  = 3'd4;

    // queue control word fields
    localparam int CTL_EN       = 0;
    localparam int CTL_FLUSH    = 1;
    localparam int CTL_TRIG_LSB = 8;
    localparam int TRIG_W       = 6;

    // status word fields
    localparam int FLD_W         = 6;
    localparam int ST_RXFILL_LSB = 0;
    localparam int ST_TXFILL_LSB = 8;
    localparam int ST_TXFREE_LSB = 24;

    // interrupt bit positions
    localparam int IRQ_TX    = 0;
    localparam int IRQ_RX    = 1;
    localparam int IRQ_ERR   = 2;
    localparam int IRQ_TXBUF = 3;
    localparam int NPEND     = 3;
    localparam int NIEN      = 4;

    typedef struct packed {
        logic              en;
        logic [TRIG_W-1:0] trig;
    } qctl_t;

    typedef struct packed {
        qctl_t           rx;
        qctl_t           tx;
        logic [NIEN-1:0] ien;
    } cfg_t;

endpackage

// File: rtl/uart_char_fifo.sv
module uart_char_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head_data,
    output logic [CW-1:0] fill
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PW-1:0]            wr;
        logic [PW-1:0]            rd;
        logic [CW-1:0]            cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     full, empty, push_ok, pop_ok;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (st_q.cnt == CW'(DEPTH));
    assign empty   = (st_q.cnt == '0);
    assign push_ok = en && push && !full;
    assign pop_ok  = pop && !empty;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.wr  = '0;
            st_d.rd  = '0;
            st_d.cnt = '0;
        end else begin
            if (push_ok) begin
                st_d.mem[st_q.wr] = push_data;
                st_d.wr           = ptr_inc(st_q.wr);
            end
            if (pop_ok) begin
                st_d.rd = ptr_inc(st_q.rd);
            end
            case ({push_ok, pop_ok})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_data = empty ? '0 : st_q.mem[st_q.rd];
    assign fill      = st_q.cnt;

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_fifo_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW-1:0]     rx_fill,
    input  logic [CW-1:0]     tx_fill,
    input  qctl_t             rx_ctl,
    input  qctl_t             tx_ctl,
    input  logic              err_evt,
    input  logic [NPEND-1:0]  clr,
    input  logic [NIEN-1:0]   ien,
    output logic [NPEND-1:0]  pending,
    output logic              irq_tx,
    output logic              irq_rx,
    output logic              irq_err,
    output logic              irq_txbuf
);
    localparam int XW = (CW > TRIG_W) ? CW : TRIG_W;

    logic [NPEND-1:0] set_v;
    logic [NPEND-1:0] pend_d, pend_q;

    always_comb begin
        set_v          = '0;
        set_v[IRQ_TX]  = tx_ctl.en && (XW'(tx_fill) <= XW'(tx_ctl.trig));
        set_v[IRQ_RX]  = rx_ctl.en && (XW'(rx_fill) >= XW'(rx_ctl.trig));
        set_v[IRQ_ERR] = err_evt;
        pend_d         = (pend_q & ~clr) | set_v;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pending   = pend_q;
    assign irq_tx    = pend_q[IRQ_TX]  && ien[IRQ_TX];
    assign irq_rx    = pend_q[IRQ_RX]  && ien[IRQ_RX];
    assign irq_err   = pend_q[IRQ_ERR] && ien[IRQ_ERR];
    assign irq_txbuf = ien[IRQ_TXBUF] && (tx_fill == '0);

endmodule

// File: rtl/uart_fifo_irq.sv
module uart_fifo_irq
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              host_tx_push,
    input  logic [DW-1:0]     host_tx_data,
    input  logic              host_rx_pop,
    output logic [DW-1:0]     host_rx_data,
    input  logic              shf_rx_push,
    input  logic [DW-1:0]     shf_rx_data,
    input  logic              shf_rx_err,
    input  logic              shf_tx_pop,
    output logic [DW-1:0]     shf_tx_data,
    output logic              shf_tx_valid,
    output logic              irq_tx,
    output logic              irq_rx,
    output logic              irq_err,
    output logic              irq_txbuf
);
    localparam int CW = $clog2(DEPTH + 1);

    cfg_t             cfg_d, cfg_q;
    logic             rx_flush, tx_flush;
    logic [NPEND-1:0] cap_clr;
    logic [NPEND-1:0] pending;
    logic [CW-1:0]    rx_fill, tx_fill, tx_free;
    logic             unused_wdata;

    assign unused_wdata = ^{reg_wdata[31:CTL_TRIG_LSB+TRIG_W], reg_wdata[CTL_TRIG_LSB-1:NIEN]};

    // configuration write decode
    always_comb begin
        cfg_d    = cfg_q;
        rx_flush = 1'b0;
        tx_flush = 1'b0;
        cap_clr  = '0;
        if (reg_wr) begin
            case (reg_addr)
                A_RXCTL: begin
                    cfg_d.rx.en   = reg_wdata[CTL_EN];
                    cfg_d.rx.trig = reg_wdata[CTL_TRIG_LSB +: TRIG_W];
                    rx_flush      = reg_wdata[CTL_FLUSH];
                end
                A_TXCTL: begin
                    cfg_d.tx.en   = reg_wdata[CTL_EN];
                    cfg_d.tx.trig = reg_wdata[CTL_TRIG_LSB +: TRIG_W];
                    tx_flush      = reg_wdata[CTL_FLUSH];
                end
                A_IEN:   cfg_d.ien = reg_wdata[NIEN-1:0];
                A_ICAP:  cap_clr   = reg_wdata[NPEND-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    uart_char_fifo #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) i_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg_q.rx.en),
        .flush     (rx_flush),
        .push      (shf_rx_push),
        .push_data (shf_rx_data),
        .pop       (host_rx_pop),
        .head_data (host_rx_data),
        .fill      (rx_fill)
    );

    uart_char_fifo #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) i_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg_q.tx.en),
        .flush     (tx_flush),
        .push      (host_tx_push),
        .push_data (host_tx_data),
        .pop       (shf_tx_pop),
        .head_data (shf_tx_data),
        .fill      (tx_fill)
    );

    uart_irq_ctrl #(.CW(CW)) i_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_fill   (rx_fill),
        .tx_fill   (tx_fill),
        .rx_ctl    (cfg_q.rx),
        .tx_ctl    (cfg_q.tx),
        .err_evt   (shf_rx_err),
        .clr       (cap_clr),
        .ien       (cfg_q.ien),
        .pending   (pending),
        .irq_tx    (irq_tx),
        .irq_rx    (irq_rx),
        .irq_err   (irq_err),
        .irq_txbuf (irq_txbuf)
    );

    assign tx_free      = CW'(DEPTH) - tx_fill;
    assign shf_tx_valid = (tx_fill != '0);

    // register readback
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_RXCTL: begin
                reg_rdata[CTL_EN]                    = cfg_q.rx.en;
                reg_rdata[CTL_TRIG_LSB +: TRIG_W]    = cfg_q.rx.trig;
            end
            A_TXCTL: begin
                reg_rdata[CTL_EN]                    = cfg_q.tx.en;
                reg_rdata[CTL_TRIG_LSB +: TRIG_W]    = cfg_q.tx.trig;
            end
            A_STAT: begin
                reg_rdata[ST_RXFILL_LSB +: FLD_W]    = FLD_W'(rx_fill);
                reg_rdata[ST_TXFILL_LSB +: FLD_W]    = FLD_W'(tx_fill);
                reg_rdata[ST_TXFREE_LSB +: FLD_W]    = FLD_W'(tx_free);
            end
            A_IEN:   reg_rdata[NIEN-1:0]  = cfg_q.ien;
            A_ICAP:  reg_rdata[NPEND-1:0] = pending;
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/uart_fifo_irq_chk.sv
module uart_fifo_irq_chk #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_flush,
    input logic          tx_flush,
    input logic          shf_rx_push,
    input logic          host_rx_pop,
    input logic          shf_rx_err,
    input logic [CW-1:0] rx_fill,
    input logic [CW-1:0] tx_fill,
    input logic [2:0]    pending,
    input logic [DW-1:0] host_rx_data
);

    // R2
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_fill <= CW'(DEPTH)) && (tx_fill <= CW'(DEPTH)));

    // R5
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_flush || tx_flush) |=> ((!$past(rx_flush) || rx_fill == '0) &&
                                    (!$past(tx_flush) || tx_fill == '0)));

    // R6
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_fill == CW'(DEPTH) && shf_rx_push && !host_rx_pop && !rx_flush)
            |=> (rx_fill == CW'(DEPTH)));

    // R6
    empty_pop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_fill == '0) |-> (host_rx_data == '0));

    // R9
    err_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shf_rx_err |=> pending[2]);

endmodule

bind uart_fifo_irq uart_fifo_irq_chk #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_flush     (rx_flush),
    .tx_flush     (tx_flush),
    .shf_rx_push  (shf_rx_push),
    .host_rx_pop  (host_rx_pop),
    .shf_rx_err   (shf_rx_err),
    .rx_fill      (rx_fill),
    .tx_fill      (tx_fill),
    .pending      (pending),
    .host_rx_data (host_rx_data)
);

// File: tb/test_uart_fifo_irq.sv
module test_uart_fifo_irq;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        host_tx_push;
    logic [7:0]  host_tx_data;
    logic        host_rx_pop;
    logic [7:0]  host_rx_data;
    logic        shf_rx_push;
    logic [7:0]  shf_rx_data;
    logic        shf_rx_err;
    logic        shf_tx_pop;
    logic [7:0]  shf_tx_data;
    logic        shf_tx_valid;
    logic        irq_tx, irq_rx, irq_err, irq_txbuf;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_fifo_irq i_uart_fifo_irq (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .host_tx_push(host_tx_push), .host_tx_data(host_tx_data),
        .host_rx_pop(host_rx_pop), .host_rx_data(host_rx_data),
        .shf_rx_push(shf_rx_push), .shf_rx_data(shf_rx_data), .shf_rx_err(shf_rx_err),
        .shf_tx_pop(shf_tx_pop), .shf_tx_data(shf_tx_data), .shf_tx_valid(shf_tx_valid),
        .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err), .irq_txbuf(irq_txbuf)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic rx_push(input logic [7:0] d);
        @(negedge clk);
        shf_rx_push = 1'b1; shf_rx_data = d;
        @(negedge clk);
        shf_rx_push = 1'b0;
    endtask

    task automatic tx_push(input logic [7:0] d);
        @(negedge clk);
        host_tx_push = 1'b1; host_tx_data = d;
        @(negedge clk);
        host_tx_push = 1'b0;
    endtask

    task automatic rx_pop(output logic [7:0] d);
        @(negedge clk);
        #1;
        d = host_rx_data;
        host_rx_pop = 1'b1;
        @(negedge clk);
        host_rx_pop = 1'b0;
    endtask

    task automatic tx_pop(output logic [7:0] d, output logic v);
        @(negedge clk);
        #1;
        d = shf_tx_data; v = shf_tx_valid;
        shf_tx_pop = 1'b1;
        @(negedge clk);
        shf_tx_pop = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] r;
        rd(3'd2, r); chk("R1 status", r, 32'h1000_0000);
        rd(3'd0, r); chk("R1 rx ctl", r, 0);
        rd(3'd1, r); chk("R1 tx ctl", r, 0);
        rd(3'd3, r); chk("R1 ien", r, 0);
        rd(3'd4, r); chk("R1 capture", r, 0);
        chk("R1 irqs", {28'd0, irq_tx, irq_rx, irq_err, irq_txbuf}, 0);
    endtask

    task automatic t_disabled;
        logic [31:0] r;
        rx_push(8'h55);
        tx_push(8'h66);
        rd(3'd2, r); chk("R4 disabled push dropped", r, 32'h1000_0000);
    endtask

    task automatic t_order;
        logic [31:0] r;
        logic [7:0]  d;
        logic        v;
        wr(3'd0, 32'h1);
        wr(3'd1, 32'h1);
        rx_push(8'hA1); rx_push(8'hB2); rx_push(8'hC3);
        for (int i = 0; i < 5; i++) tx_push(8'h10 + 8'(i));
        rd(3'd2, r); chk("R3 status fields", r, (32'd11 << 24) | (32'd5 << 8) | 32'd3);
        rx_pop(d); chk("R2 rx order 0", {24'd0, d}, 32'hA1);
        rx_pop(d); chk("R2 rx order 1", {24'd0, d}, 32'hB2);
        rx_pop(d); chk("R2 rx order 2", {24'd0, d}, 32'hC3);
        for (int i = 0; i < 5; i++) begin
            tx_pop(d, v);
            chk("R2 tx order", {23'd0, v, d}, {23'd0, 1'b1, 8'h10 + 8'(i)});
        end
        #1;
        chk("R2 tx valid low when empty", {31'd0, shf_tx_valid}, 0);
    endtask

    task automatic t_full;
        logic [31:0] r;
        logic [7:0]  d;
        wr(3'd0, 32'h3);
        for (int i = 0; i <= DEPTH; i++) rx_push(8'(i + 1));
        rd(3'd2, r); chk("R6 full count", r & 32'h3F, 32'd16);
        for (int i = 0; i < DEPTH; i++) begin
            rx_pop(d); chk("R6 full contents", {24'd0, d}, 32'(i + 1));
        end
        rx_pop(d); chk("R6 empty pop zero", {24'd0, d}, 0);
        rd(3'd2, r); chk("R6 empty count", r & 32'h3F, 0);
    endtask

    task automatic t_flush;
        logic [31:0] r;
        for (int i = 0; i < 4; i++) tx_push(8'h40 + 8'(i));
        rd(3'd2, r); chk("R5 pre flush fill", (r >> 8) & 32'h3F, 4);
        wr(3'd1, 32'h3);
        rd(3'd2, r); chk("R5 flushed", r, 32'h1000_0000);
        rd(3'd1, r); chk("R5 flush reads 0", r, 32'h1);
        wr(3'd1, 32'h0501);
        rd(3'd1, r); chk("R4 trigger readback", r, 32'h0501);
    endtask

    task automatic t_rx_irq;
        logic [31:0] r;
        logic [7:0]  d;
        wr(3'd0, 32'h0303);
        wr(3'd3, 32'h2);
        wr(3'd4, 32'h7);
        rx_push(8'h01); rx_push(8'h02); idle(1);
        rd(3'd4, r); chk("R7 below trigger", r & 32'h2, 0);
        chk("R7 irq_rx low", {31'd0, irq_rx}, 0);
        rx_push(8'h03); idle(1);
        chk("R7 irq_rx at trigger", {31'd0, irq_rx}, 1);
        wr(3'd4, 32'h2);
        chk("R11 clear while held", {31'd0, irq_rx}, 1);
        rx_pop(d); idle(1);
        wr(3'd4, 32'h2);
        chk("R11 clear after drop", {31'd0, irq_rx}, 0);
        wr(3'd0, 32'h3);
    endtask

    task automatic t_tx_irq;
        logic [7:0] d;
        logic       v;
        wr(3'd1, 32'h0103);
        wr(3'd3, 32'h1);
        idle(1);
        chk("R8 irq_tx empty", {31'd0, irq_tx}, 1);
        tx_push(8'h21); tx_push(8'h22); tx_push(8'h23); idle(1);
        wr(3'd4, 32'h1);
        chk("R8 irq_tx above trigger", {31'd0, irq_tx}, 0);
        tx_pop(d, v); tx_pop(d, v); idle(1);
        chk("R8 irq_tx at trigger", {31'd0, irq_tx}, 1);
        wr(3'd3, 32'h9);
        chk("R12 txbuf low with data", {31'd0, irq_txbuf}, 0);
        tx_pop(d, v);
        chk("R12 txbuf high when empty", {31'd0, irq_txbuf}, 1);
    endtask

    task automatic t_err;
        logic [31:0] r;
        wr(3'd3, 32'h0);
        wr(3'd1, 32'h0);
        wr(3'd4, 32'h7);
        @(negedge clk); shf_rx_err = 1'b1;
        @(negedge clk); shf_rx_err = 1'b0;
        rd(3'd4, r); chk("R9 error pending", r & 32'h4, 32'h4);
        chk("R10 irq_err gated", {31'd0, irq_err}, 0);
        wr(3'd3, 32'h4);
        chk("R10 irq_err enabled", {31'd0, irq_err}, 1);
        wr(3'd4, 32'h0);
        chk("R11 zero write no effect", {31'd0, irq_err}, 1);
        wr(3'd4, 32'h4);
        rd(3'd4, r);
        chk("R11 error cleared", {30'd0, irq_err, r[2]}, 0);
    endtask

    initial begin
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        host_tx_push = 1'b0; host_tx_data = '0; host_rx_pop = 1'b0;
        shf_rx_push = 1'b0; shf_rx_data = '0; shf_rx_err = 1'b0; shf_tx_pop = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset;
        t_disabled;
        t_order;
        t_full;
        t_flush;
        t_rx_irq;
        t_tx_irq;
        t_err;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule